// File: doc/BRIEF.md
# Ethernet receive destination-address filter

This block decides, for each received Ethernet frame, whether the frame should be kept, based only on its 48-bit destination address. The MAC front end presents the address with a one-cycle valid strobe. The front end also supplies two hash-table lookups, which are computed elsewhere: one from the individual-address table and one from the group-address table. The block tells the two kinds of address apart by the group bit. It then follows one of two paths. An individual (unicast) address is compared exactly with the programmed station address and, if that fails, is tested against the individual hash hit. A group address is tested for the all-ones broadcast value first, and then against the group hash hit.

A promiscuous setting overrides rejection. When it is set, every frame is kept. The decision is registered and appears one clock after the strobe, together with a result-valid pulse and a reason code that names the path that accepted the frame.

Software can choose how individual frames are matched. To keep only hash matches, it programs the station address to all ones, which a unicast address can never equal. To keep only exact matches, it clears the individual hash table.

The address is presented first byte in bits [47:40]. The group bit is bit 40, the least significant bit of that first byte.

Top module: `rxaf_filter`

## Requirements
- R1: After reset, and until the first strobe has been registered, res_valid and res_accept are 0 and res_reason is 0 (none).
- R2: An address with bit 40 clear that equals phys_addr exactly is accepted with reason 1 (physical). This holds even when ihash_hit is also set.
- R3: An address with bit 40 clear that differs from phys_addr is accepted with reason 2 (individual hash) when ihash_hit is 1.
- R4: An address with bit 40 clear that matches neither phys_addr nor the individual hash is rejected. ghash_hit has no effect on such an address.
- R5: The all-ones address is accepted with reason 3 (broadcast) when bcast_en is 1. When bcast_en is 0 it is rejected, even if ghash_hit is 1.
- R6: An address with bit 40 set that is not all ones is accepted with reason 4 (group hash) exactly when ghash_hit is 1. ihash_hit and phys_addr have no effect on such an address.
- R7: When promisc_en is 1, every frame is accepted. The reason is 5 (promiscuous) only when no other path accepts the frame; otherwise the reason is the code of the path that matched.
- R8: res_valid is 1 exactly in the cycle after a cycle with dst_valid high. In every cycle where res_valid is 0, res_accept is 0 and res_reason is 0.
- R9: A frame with res_valid 1 and res_accept 0 carries reason 0. Every accepted frame carries a nonzero reason.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dst_valid | input | 1 | Destination address strobe |
| dst_addr | input | 48 | Destination address, first byte in [47:40] |
| phys_addr | input | 48 | Programmed station address |
| bcast_en | input | 1 | Accept the broadcast address |
| promisc_en | input | 1 | Accept every frame |
| ihash_hit | input | 1 | Individual hash table bit is set for this address |
| ghash_hit | input | 1 | Group hash table bit is set for this address |
| res_valid | output | 1 | Decision valid, one cycle after the strobe |
| res_accept | output | 1 | Frame accepted |
| res_reason | output | 3 | 0 none, 1 physical, 2 individual hash, 3 broadcast, 4 group hash, 5 promiscuous |

## Verification
The assertions check several properties on every cycle. They check the one-cycle strobe-to-result timing and the idle zero outputs. They check that the reason code agrees with the accept bit. They check that promiscuous mode always accepts. They check that a disabled broadcast, or a group address without a hash hit, is never accepted. Only the bench's directed scenarios can show the priority of the paths. This covers the exact match winning over the individual hash and the specific reason codes under promiscuous mode. It also covers the inputs each path is meant to ignore, and the software idioms of an all-ones station address or a cleared individual table.

// File: rtl/rxaf_pkg.sv
package rxaf_pkg;
  parameter int unsigned MAC_W = 48;
  localparam int unsigned GRP_BIT = MAC_W - 8;

  typedef enum logic [2:0] {
    RSN_NONE    = 3'd0,
    RSN_PHYS    = 3'd1,
    RSN_IHASH   = 3'd2,
    RSN_BCAST   = 3'd3,
    RSN_GHASH   = 3'd4,
    RSN_PROMISC = 3'd5
  } reason_e;

  // group bit: LSB of the first byte on the wire
  function automatic logic addr_is_group(input logic [MAC_W-1:0] a);
    return a[GRP_BIT];
  endfunction

  function automatic logic addr_is_bcast(input logic [MAC_W-1:0] a);
    return &a;
  endfunction
endpackage

// File: rtl/rxaf_unicast_path.sv
module rxaf_unicast_path
  import rxaf_pkg::*;
#(
  parameter int unsigned W = MAC_W
) (
  input  logic [W-1:0] addr,
  input  logic [W-1:0] station,
  input  logic         ihash_hit,
  output logic         phys_hit,
  output logic         ihash_ok
);
  // both checks always run; the decider applies priority
  always_comb begin
    phys_hit = (addr == station);
    ihash_ok = ihash_hit;
  end
endmodule

// File: rtl/rxaf_group_path.sv
module rxaf_group_path
  import rxaf_pkg::*;
#(
  parameter int unsigned W = MAC_W
) (
  input  logic [W-1:0] addr,
  input  logic         bcast_en,
  input  logic         ghash_hit,
  output logic         bcast_seen,
  output logic         bcast_ok,
  output logic         ghash_ok
);
  always_comb begin
    bcast_seen = addr_is_bcast(addr);
    bcast_ok   = bcast_seen && bcast_en;
    // broadcast never falls through to the hash test
    ghash_ok   = !bcast_seen && ghash_hit;
  end
endmodule

// File: rtl/rxaf_decide.sv
module rxaf_decide
  import rxaf_pkg::*;
(
  input  logic    is_group,
  input  logic    promisc_en,
  input  logic    phys_hit,
  input  logic    ihash_ok,
  input  logic    bcast_ok,
  input  logic    ghash_ok,
  output logic    accept,
  output reason_e reason
);
  always_comb begin
    reason = RSN_NONE;
    if (!is_group) begin
      if (phys_hit)      reason = RSN_PHYS;
      else if (ihash_ok) reason = RSN_IHASH;
    end else begin
      if (bcast_ok)      reason = RSN_BCAST;
      else if (ghash_ok) reason = RSN_GHASH;
    end
    if (reason == RSN_NONE && promisc_en) reason = RSN_PROMISC;
    accept = (reason != RSN_NONE);
  end
endmodule

// File: rtl/rxaf_filter.sv
module rxaf_filter
  import rxaf_pkg::*;
#(
  parameter int unsigned ADDR_W = MAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dst_valid,
  input  logic [ADDR_W-1:0] dst_addr,
  input  logic [ADDR_W-1:0] phys_addr,
  input  logic              bcast_en,
  input  logic              promisc_en,
  input  logic              ihash_hit,
  input  logic              ghash_hit,
  output logic              res_valid,
  output logic              res_accept,
  output logic [2:0]        res_reason
);
  // named internal events, visible to the checker
  logic    is_group;
  logic    phys_hit, ihash_ok;
  logic    bcast_seen, bcast_ok, ghash_ok;
  logic    dec_accept;
  reason_e dec_reason;

  assign is_group = addr_is_group(dst_addr);

  rxaf_unicast_path #(.W(ADDR_W)) u_uni (
    .addr      (dst_addr),
    .station   (phys_addr),
    .ihash_hit (ihash_hit),
    .phys_hit  (phys_hit),
    .ihash_ok  (ihash_ok)
  );

  rxaf_group_path #(.W(ADDR_W)) u_grp (
    .addr       (dst_addr),
    .bcast_en   (bcast_en),
    .ghash_hit  (ghash_hit),
    .bcast_seen (bcast_seen),
    .bcast_ok   (bcast_ok),
    .ghash_ok   (ghash_ok)
  );

  rxaf_decide u_dec (
    .is_group   (is_group),
    .promisc_en (promisc_en),
    .phys_hit   (phys_hit),
    .ihash_ok   (ihash_ok),
    .bcast_ok   (bcast_ok),
    .ghash_ok   (ghash_ok),
    .accept     (dec_accept),
    .reason     (dec_reason)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_accept <= 1'b0;
      res_reason <= RSN_NONE;
    end else begin
      res_valid  <= dst_valid;
      res_accept <= dst_valid && dec_accept;
      res_reason <= dst_valid ? dec_reason : RSN_NONE;
    end
  end
endmodule

// File: rtl/rxaf_filter_chk.sv
module rxaf_filter_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        dst_valid,
  input logic        promisc_en,
  input logic        bcast_en,
  input logic        ghash_hit,
  input logic        is_group,
  input logic        bcast_seen,
  input logic        res_valid,
  input logic        res_accept,
  input logic [2:0]  res_reason
);
  p_strobe_lat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dst_valid |=> res_valid);
  p_no_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !dst_valid |=> !res_valid);
  p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> (!res_accept && res_reason == 3'd0));
  p_reason_agree_r9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_accept == (res_reason != 3'd0)));
  p_promisc_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_valid && promisc_en) |=> res_accept);
  p_bcast_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_valid && bcast_seen && !bcast_en && !promisc_en) |=> !res_accept);
  p_group_miss_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_valid && is_group && !bcast_seen && !ghash_hit && !promisc_en) |=> !res_accept);
  p_reason_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    res_reason <= 3'd5);
endmodule

bind rxaf_filter rxaf_filter_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .dst_valid  (dst_valid),
  .promisc_en (promisc_en),
  .bcast_en   (bcast_en),
  .ghash_hit  (ghash_hit),
  .is_group   (is_group),
  .bcast_seen (bcast_seen),
  .res_valid  (res_valid),
  .res_accept (res_accept),
  .res_reason (res_reason)
);

// File: tb/rxaf_filter_bench.sv
module rxaf_filter_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dst_valid = 1'b0;
  logic [47:0] dst_addr = '0;
  logic [47:0] phys_addr = '0;
  logic        bcast_en = 1'b0;
  logic        promisc_en = 1'b0;
  logic        ihash_hit = 1'b0;
  logic        ghash_hit = 1'b0;
  logic        res_valid, res_accept;
  logic [2:0]  res_reason;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rxaf_filter u_rxaf_filter (
    .clk(clk), .rst_n(rst_n), .dst_valid(dst_valid), .dst_addr(dst_addr),
    .phys_addr(phys_addr), .bcast_en(bcast_en), .promisc_en(promisc_en),
    .ihash_hit(ihash_hit), .ghash_hit(ghash_hit),
    .res_valid(res_valid), .res_accept(res_accept), .res_reason(res_reason)
  );

  localparam logic [47:0] STATION = 48'h02_11_22_33_44_55;
  localparam logic [47:0] OTHER_U = 48'h00_A0_B0_C0_D0_E0;
  localparam logic [47:0] GROUP_A = 48'h01_00_5E_00_00_FB;
  localparam logic [47:0] ALL_ONE = {48{1'b1}};

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Drive one address, sample the registered result one cycle later, then idle.
  task automatic frame(input string req, input logic [47:0] a, input logic [47:0] st,
                       input logic be, input logic pe, input logic ih, input logic gh,
                       input int exp_acc, input int exp_rsn);
    @(negedge clk);
    dst_valid = 1'b1; dst_addr = a; phys_addr = st;
    bcast_en = be; promisc_en = pe; ihash_hit = ih; ghash_hit = gh;
    @(negedge clk);
    dst_valid = 1'b0;
    check(req, "valid", int'(res_valid), 1);
    check(req, "accept", int'(res_accept), exp_acc);
    check(req, "reason", int'(res_reason), exp_rsn);
    @(negedge clk);
    check("R8", "idle valid", int'(res_valid), 0);
    check("R8", "idle accept", int'(res_accept), 0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1", "reset valid", int'(res_valid), 0);
    check("R1", "reset accept", int'(res_accept), 0);
    check("R1", "reset reason", int'(res_reason), 0);
  endtask

  task automatic t_physical; // R2
    frame("R2", STATION, STATION, 0, 0, 0, 0, 1, 1);
    frame("R2", STATION, STATION, 0, 0, 1, 1, 1, 1);
  endtask

  task automatic t_ihash; // R3
    frame("R3", OTHER_U, STATION, 0, 0, 1, 0, 1, 2);
    frame("R3", OTHER_U, ALL_ONE, 0, 0, 1, 0, 1, 2);
    frame("R3", STATION, ALL_ONE, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_unicast_miss; // R4
    frame("R4", OTHER_U, STATION, 1, 0, 0, 1, 0, 0);
  endtask

  task automatic t_broadcast; // R5
    frame("R5", ALL_ONE, STATION, 1, 0, 0, 0, 1, 3);
    frame("R5", ALL_ONE, STATION, 0, 0, 1, 1, 0, 0);
    frame("R5", ALL_ONE, ALL_ONE, 0, 0, 1, 0, 0, 0);
  endtask

  task automatic t_group; // R6
    frame("R6", GROUP_A, STATION, 1, 0, 0, 1, 1, 4);
    frame("R6", GROUP_A, GROUP_A, 1, 0, 1, 0, 0, 0);
  endtask

  task automatic t_promisc; // R7
    frame("R7", OTHER_U, STATION, 0, 1, 0, 0, 1, 5);
    frame("R7", ALL_ONE, STATION, 0, 1, 0, 1, 1, 5);
    frame("R7", STATION, STATION, 0, 1, 0, 0, 1, 1);
    frame("R7", GROUP_A, STATION, 0, 1, 0, 1, 1, 4);
  endtask

  task automatic t_back_to_back; // R8, R9
    @(negedge clk);
    dst_valid = 1'b1; dst_addr = OTHER_U; phys_addr = STATION;
    bcast_en = 0; promisc_en = 0; ihash_hit = 0; ghash_hit = 0;
    @(negedge clk);
    check("R9", "reject reason", int'(res_reason), 0);
    check("R8", "b2b valid1", int'(res_valid), 1);
    dst_addr = STATION;
    @(negedge clk);
    dst_valid = 1'b0;
    check("R8", "b2b valid2", int'(res_valid), 1);
    check("R8", "b2b reason2", int'(res_reason), 1);
    @(negedge clk);
    check("R8", "b2b idle", int'(res_reason), 0);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_physical();
    t_ihash();
    t_unicast_miss();
    t_broadcast();
    t_group();
    t_promisc();
    t_back_to_back();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule